// File: doc/BRIEF.md
# I2C Bus Clock and Condition Timing Engine

This block turns programmed cycle counts into the SCL and SDA change points of an I2C controller. A sequencer asks for one bus phase at a time: a START condition, one data bit, a repeated START, or a STOP. The block then drives both lines through that phase with the programmed timing. It raises `done_o` when the phase has finished and waits for the next request. While the clock is high during a data bit, it pulses `sample_o` so the sequencer can read SDA at a stable point.

Every count is scaled by a shared prescaler of divide ratio DIV+1. The prescaler runs from 1 to 256, because DIV is 8 bits. After each SCL edge the engine also waits a fixed settle time of 4 + FILTER input clocks, where FILTER is a 3-bit glitch-filter count. A full bit therefore takes (DIV+1)·(SCL_L+SCL_H+2) + 8 + 2·FILTER clocks. The counts come in two sets, fast and high-speed. A START condition always uses the fast set, because every transfer begins in fast timing. Other phases use the set the request selects. High-time counting waits until the line is seen high, so a target can stretch the clock.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, both lines are released (`scl_o`=1, `sda_o`=1; 1 means released), and `busy_o`, `done_o` and `sample_o` are 0.
- R2: A bit phase lasts (K)·(SCL_L+SCL_H+2) + 8 + 2·FILTER clocks when HOLD+DSU ≤ SCL_L, with K = DIV+1. The parts are:
  - SCL low for (SCL_L+1)·K clocks;
  - SCL released for 4+FILTER clocks;
  - SCL high for (SCL_H+1)·K clocks;
  - SCL low for 4+FILTER clocks.
  SDA does not change while SCL is high.
- R3: In a bit phase, SDA takes the new bit HOLD·K clocks after the phase is accepted (HOLD = `hold_i`). SCL is released only once DSU·K clocks have passed since that change. The low part therefore lasts max(SCL_L+1, HOLD+DSU+1)·K clocks.
- R4: A START runs from the idle bus. SDA falls (STA_SU+1)·K clocks after acceptance while SCL stays high. SCL falls (STA_HD+1)·K clocks later. `done_o` follows 4+FILTER clocks after that.
- R5: A STOP runs as follows:
  - SDA is driven low at once, with SCL low, for (SCL_L+1)·K clocks;
  - SCL is released and settles for 4+FILTER clocks;
  - after a further (STO_SU+1)·K clocks, SDA is released in the same cycle as `done_o`.
- R6: A repeated START runs as follows:
  - SDA is released at once, with SCL low, for (RS_REL+1)·K clocks;
  - SCL is released and settles for 4+FILTER clocks;
  - the START timing of R4 follows.
- R7: During the settle after SCL is released, the high phase starts only in the cycle after `scl_i` reads 1. A target holding SCL low delays it.
- R8: In a bit phase, `sample_o` pulses for one clock ((SCL_H+1)/2)·K clocks after the high part begins.
- R9: Each set arrives as three words:
  - edge word {STA_SU, STA_HD, STO_SU}, most significant field first;
  - bit word {DSU, SCL_L, SCL_H};
  - rate word {DIV, RS_REL}, all fields 8 bits.
  A START uses the fast set whatever `req_hs_i` says. The other phases use the high-speed set when `req_hs_i` was 1 at acceptance.
- R10: A request is accepted on a clock edge with `req_valid_i`=1 while idle. The op codes are 0 START, 1 bit, 2 repeated START and 3 STOP. `busy_o` is 1 from the acceptance edge to the end of the phase. `done_o` is a one-clock pulse in the first idle cycle. Requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_edge_i | input | 24 | Fast set: START setup, START hold, STOP setup |
| fs_bit_i | input | 24 | Fast set: data setup, SCL low, SCL high |
| fs_rate_i | input | 16 | Fast set: divider, repeated-start release |
| hs_edge_i | input | 24 | High-speed set: START setup, START hold, STOP setup |
| hs_bit_i | input | 24 | High-speed set: data setup, SCL low, SCL high |
| hs_rate_i | input | 16 | High-speed set: divider, repeated-start release |
| hold_i | input | 8 | Data hold count, shared by both sets |
| filt_i | input | 3 | Glitch-filter cycle count |
| req_valid_i | input | 1 | Phase request |
| req_op_i | input | 2 | Phase kind |
| req_bit_i | input | 1 | SDA value for a bit phase |
| req_hs_i | input | 1 | Select the high-speed set |
| scl_i | input | 1 | Sampled SCL line level |
| scl_o | output | 1 | SCL drive, 1 = released |
| sda_o | output | 1 | SDA drive, 1 = released |
| sample_o | output | 1 | Mid-high sample strobe |
| done_o | output | 1 | Phase complete pulse |
| busy_o | output | 1 | Phase in progress |

## Verification
The bench uses the default parameters: 8-bit counts, a 3-bit filter and a base settle of four clocks. It programs small counts so that every phase completes in a few dozen clocks.

The fast set uses a divide ratio of 3 and the high-speed set a ratio of 1, which exercises both unscaled and scaled segments. A START issued under the high-speed select shows that the fast set is forced. Raising the hold count above the low count exercises the extended low time. Dropping the filter to zero changes the settle length. One stretch case holds `scl_i` low past the settle time.

// File: rtl/scl_timing_pkg.sv
`timescale 1ns/1ps
package scl_timing_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    OP_START  = 2'd0,
    OP_BIT    = 2'd1,
    OP_RSTART = 2'd2,
    OP_STOP   = 2'd3
  } phase_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SSU, S_SHD, S_LOW, S_RISE, S_HIGH, S_FALL, S_RREL, S_PSU
  } seg_e;

  typedef struct packed {
    logic [CNT_W-1:0] div;
    logic [CNT_W-1:0] scl_lo;
    logic [CNT_W-1:0] scl_hi;
    logic [CNT_W-1:0] sta_su;
    logic [CNT_W-1:0] sta_hd;
    logic [CNT_W-1:0] sto_su;
    logic [CNT_W-1:0] dat_su;
    logic [CNT_W-1:0] rs_rel;
  } tim_set_t;
endpackage

// File: rtl/scl_set_sel.sv
`timescale 1ns/1ps
module scl_set_sel
  import scl_timing_pkg::*;
(
  input  logic [3*CNT_W-1:0] fs_edge_i,
  input  logic [3*CNT_W-1:0] fs_bit_i,
  input  logic [2*CNT_W-1:0] fs_rate_i,
  input  logic [3*CNT_W-1:0] hs_edge_i,
  input  logic [3*CNT_W-1:0] hs_bit_i,
  input  logic [2*CNT_W-1:0] hs_rate_i,
  input  logic               use_hs_i,
  output tim_set_t           set_o
);
  localparam int NSETS = 2;

  logic [3*CNT_W-1:0] edge_w [NSETS];
  logic [3*CNT_W-1:0] bit_w  [NSETS];
  logic [2*CNT_W-1:0] rate_w [NSETS];
  tim_set_t           sets   [NSETS];

  assign edge_w[0] = fs_edge_i;
  assign edge_w[1] = hs_edge_i;
  assign bit_w[0]  = fs_bit_i;
  assign bit_w[1]  = hs_bit_i;
  assign rate_w[0] = fs_rate_i;
  assign rate_w[1] = hs_rate_i;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    assign sets[g] = {rate_w[g][2*CNT_W-1 -: CNT_W],   // div
                      bit_w[g][2*CNT_W-1 -: CNT_W],    // scl_lo
                      bit_w[g][CNT_W-1:0],             // scl_hi
                      edge_w[g][3*CNT_W-1 -: CNT_W],   // sta_su
                      edge_w[g][2*CNT_W-1 -: CNT_W],   // sta_hd
                      edge_w[g][CNT_W-1:0],            // sto_su
                      bit_w[g][3*CNT_W-1 -: CNT_W],    // dat_su
                      rate_w[g][CNT_W-1:0]};           // rs_rel
  end

  assign set_o = sets[use_hs_i];
endmodule

// File: rtl/scl_unit_timer.sv
`timescale 1ns/1ps
module scl_unit_timer #(
  parameter int DIV_W  = 8,
  parameter int UNIT_W = 10,
  parameter int CLK_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              tick_o,
  output logic              pre_zero_o,
  output logic [UNIT_W-1:0] units_o,
  output logic [CLK_W-1:0]  clocks_o
);
  logic [DIV_W-1:0]  pre_q;
  logic [UNIT_W-1:0] units_q;
  logic [CLK_W-1:0]  clk_q;

  assign tick_o     = (pre_q == div_i);
  assign pre_zero_o = (pre_q == '0);
  assign units_o    = units_q;
  assign clocks_o   = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      units_q <= '0;
      clk_q   <= '0;
    end else if (clear_i) begin
      pre_q   <= '0;
      units_q <= '0;
      clk_q   <= '0;
    end else begin
      if (tick_o) begin
        pre_q   <= '0;
        units_q <= units_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
      if (clk_q != '1) clk_q <= clk_q + 1'b1;  // saturate while stretched
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int FILT_W  = 3,
  parameter int OV_BASE = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3*CNT_W-1:0] fs_edge_i,
  input  logic [3*CNT_W-1:0] fs_bit_i,
  input  logic [2*CNT_W-1:0] fs_rate_i,
  input  logic [3*CNT_W-1:0] hs_edge_i,
  input  logic [3*CNT_W-1:0] hs_bit_i,
  input  logic [2*CNT_W-1:0] hs_rate_i,
  input  logic [CNT_W-1:0]   hold_i,
  input  logic [FILT_W-1:0]  filt_i,
  input  logic               req_valid_i,
  input  logic [1:0]         req_op_i,
  input  logic               req_bit_i,
  input  logic               req_hs_i,
  input  logic               scl_i,
  output logic               scl_o,
  output logic               sda_o,
  output logic               sample_o,
  output logic               done_o,
  output logic               busy_o
);
  localparam int UNIT_W = CNT_W + 2;
  localparam int CLK_W  = FILT_W + 2;

  seg_e       state_q, state_n;
  phase_op_e  op_q;
  logic       bit_q, hs_q, scl_hold_q, sda_hold_q, done_q;
  tim_set_t   cfg;
  logic              tick, pre_zero, clear;
  logic [UNIT_W-1:0] units;
  logic [CLK_W-1:0]  clocks;
  logic [UNIT_W-1:0] t_lo, t_hi, t_ssu, t_shd, t_psu, t_rel, t_low, t_dat, t_hd, mid;
  logic              ov_done, accept, finish;

  scl_set_sel i_set (
    .fs_edge_i (fs_edge_i), .fs_bit_i (fs_bit_i), .fs_rate_i (fs_rate_i),
    .hs_edge_i (hs_edge_i), .hs_bit_i (hs_bit_i), .hs_rate_i (hs_rate_i),
    .use_hs_i  (hs_q && (op_q != OP_START)),
    .set_o     (cfg)
  );

  scl_unit_timer #(.DIV_W(CNT_W), .UNIT_W(UNIT_W), .CLK_W(CLK_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .div_i      (cfg.div),
    .tick_o     (tick),
    .pre_zero_o (pre_zero),
    .units_o    (units),
    .clocks_o   (clocks)
  );

  // segment targets in prescaled units
  assign t_lo  = UNIT_W'(cfg.scl_lo) + 1'b1;
  assign t_hi  = UNIT_W'(cfg.scl_hi) + 1'b1;
  assign t_ssu = UNIT_W'(cfg.sta_su) + 1'b1;
  assign t_shd = UNIT_W'(cfg.sta_hd) + 1'b1;
  assign t_psu = UNIT_W'(cfg.sto_su) + 1'b1;
  assign t_rel = UNIT_W'(cfg.rs_rel) + 1'b1;
  assign t_hd  = UNIT_W'(hold_i);
  assign t_dat = t_hd + UNIT_W'(cfg.dat_su) + 1'b1;
  assign t_low = (op_q == OP_STOP) ? t_lo : ((t_dat > t_lo) ? t_dat : t_lo);
  assign mid   = t_hi >> 1;
  assign ov_done = (clocks >= CLK_W'(OV_BASE - 1) + CLK_W'(filt_i));

  function automatic logic seg_last(input logic tk, input logic [UNIT_W-1:0] u,
                                    input logic [UNIT_W-1:0] tgt);
    return tk && ((u + 1'b1) == tgt);
  endfunction

  always_comb begin
    state_n = state_q;
    case (state_q)
      S_IDLE: if (req_valid_i) begin
        case (phase_op_e'(req_op_i))
          OP_START:  state_n = S_SSU;
          OP_BIT:    state_n = S_LOW;
          OP_RSTART: state_n = S_RREL;
          default:   state_n = S_LOW;
        endcase
      end
      S_SSU:  if (seg_last(tick, units, t_ssu)) state_n = S_SHD;
      S_SHD:  if (seg_last(tick, units, t_shd)) state_n = S_FALL;
      S_LOW:  if (seg_last(tick, units, t_low)) state_n = S_RISE;
      S_RREL: if (seg_last(tick, units, t_rel)) state_n = S_RISE;
      S_RISE: if (ov_done && scl_i) begin
        case (op_q)
          OP_BIT:    state_n = S_HIGH;
          OP_RSTART: state_n = S_SSU;
          default:   state_n = S_PSU;
        endcase
      end
      S_HIGH: if (seg_last(tick, units, t_hi))  state_n = S_FALL;
      S_FALL: if (ov_done)                      state_n = S_IDLE;
      S_PSU:  if (seg_last(tick, units, t_psu)) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  assign accept = (state_q == S_IDLE) && req_valid_i;
  assign finish = (state_q != S_IDLE) && (state_n == S_IDLE);
  assign clear  = (state_n != state_q) || (state_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      op_q       <= OP_START;
      bit_q      <= 1'b1;
      hs_q       <= 1'b0;
      scl_hold_q <= 1'b1;
      sda_hold_q <= 1'b1;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= finish;
      if (accept) begin
        op_q  <= phase_op_e'(req_op_i);
        bit_q <= req_bit_i;
        hs_q  <= req_hs_i;
      end
      if (finish) begin
        scl_hold_q <= (op_q == OP_STOP);
        sda_hold_q <= (op_q == OP_STOP) ? 1'b1 : ((op_q == OP_BIT) ? bit_q : 1'b0);
      end
    end
  end

  always_comb begin
    case (state_q)
      S_IDLE:                 scl_o = scl_hold_q;
      S_LOW, S_RREL, S_FALL:  scl_o = 1'b0;
      default:                scl_o = 1'b1;
    endcase
  end

  always_comb begin
    case (state_q)
      S_IDLE: sda_o = sda_hold_q;
      S_SSU:  sda_o = 1'b1;
      S_SHD:  sda_o = 1'b0;
      S_RREL: sda_o = 1'b1;
      S_PSU:  sda_o = 1'b0;
      S_HIGH: sda_o = bit_q;
      S_FALL: sda_o = (op_q == OP_BIT) ? bit_q : 1'b0;
      S_LOW:  sda_o = (op_q == OP_STOP) ? 1'b0 : ((units >= t_hd) ? bit_q : sda_hold_q);
      S_RISE: sda_o = (op_q == OP_BIT) ? bit_q : (op_q == OP_RSTART);
      default: sda_o = 1'b1;
    endcase
  end

  assign sample_o = (state_q == S_HIGH) && pre_zero && (units == mid);
  assign done_o   = done_q;
  assign busy_o   = (state_q != S_IDLE);

  AST_SDA_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HIGH && $past(state_q) == S_HIGH) |-> $stable(sda_o)); // R2
  AST_START_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && $fell(sda_o)) |-> (op_q == OP_START || op_q == OP_RSTART)); // R4
  AST_STOP_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_o) && scl_o && $past(scl_o)) |-> (op_q == OP_STOP && done_o)); // R5
  AST_HIGH_AFTER_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HIGH && $past(state_q) == S_RISE) |-> $past(scl_i)); // R7
  AST_SAMPLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (scl_o && scl_i)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
endmodule

// File: tb/test_scl_timing_gen.sv
`timescale 1ns/1ps
module test_scl_timing_gen;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic req_valid, req_bit, req_hs, stretch;
  logic [1:0] req_op;
  logic scl_o, sda_o, sample_o, done_o, busy_o, scl_line;
  logic [23:0] fs_edge, fs_bit, hs_edge, hs_bit;
  logic [15:0] fs_rate, hs_rate;
  logic [7:0] hold;
  logic [2:0] filt;

  // bench copy of the programmed counts
  int fd = 2, fl = 5, fh = 4, fss = 3, fsh = 2, fps = 4, fsu = 2, frr = 3;
  int hd_ = 0, hl = 3, hh = 2, hss = 1, hsh = 1, hps = 1, hsu = 1, hrr = 1;
  int hold_n = 1, filt_n = 2;

  assign fs_edge = {8'(fss), 8'(fsh), 8'(fps)};
  assign fs_bit  = {8'(fsu), 8'(fl), 8'(fh)};
  assign fs_rate = {8'(fd), 8'(frr)};
  assign hs_edge = {8'(hss), 8'(hsh), 8'(hps)};
  assign hs_bit  = {8'(hsu), 8'(hl), 8'(hh)};
  assign hs_rate = {8'(hd_), 8'(hrr)};
  assign hold    = 8'(hold_n);
  assign filt    = 3'(filt_n);
  assign scl_line = scl_o & ~stretch;

  scl_timing_gen i_scl_timing_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .fs_edge_i(fs_edge), .fs_bit_i(fs_bit), .fs_rate_i(fs_rate),
    .hs_edge_i(hs_edge), .hs_bit_i(hs_bit), .hs_rate_i(hs_rate),
    .hold_i(hold), .filt_i(filt),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_bit_i(req_bit), .req_hs_i(req_hs),
    .scl_i(scl_line),
    .scl_o(scl_o), .sda_o(sda_o), .sample_o(sample_o), .done_o(done_o), .busy_o(busy_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; int sig; bit val; string tag; } ev_t;  // sig: 0 scl, 1 sda, 2 sample, 3 done
  ev_t q[$];
  int checks = 0, errors = 0, done_at = 0;
  bit mon_on = 0, bus_sda = 1;
  logic p_scl, p_sda;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(int at, int sig, bit val, string tag);
    ev_t e;
    e.at = at; e.sig = sig; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic got(int sig, bit v);
    ev_t e;
    if (q.size() == 0) begin
      chk(0, "R10", "unexpected event sig", sig, -1);
    end else begin
      e = q.pop_front();
      chk(e.sig == sig && e.val == v, e.tag, "event kind", sig * 2 + int'(v), e.sig * 2 + int'(e.val));
      chk(e.at == cyc, e.tag, "event cycle", cyc, e.at);
    end
  endtask

  // monitor: turns output activity into events and scores them
  always @(negedge clk) if (mon_on) begin
    if (scl_o !== p_scl) got(0, scl_o);
    if (sda_o !== p_sda) got(1, sda_o);
    if (sample_o) got(2, 1'b1);
    if (done_o) got(3, 1'b1);
    p_scl = scl_o;
    p_sda = sda_o;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (cyc < done_at) @(negedge clk);
  endtask

  // driver: predicts the events of one phase, then issues the request
  task automatic phase(int op, bit b, bit hs, string tag, int st_extra);
    int k, l, h, ss, sh, ps, su, rr, a, ov, t, r, hs0, f, s1, s2, e, rel_at;
    bit use_hs;
    wait_idle();
    use_hs = hs && (op != 0);
    k  = (use_hs ? hd_ : fd) + 1;
    l  = use_hs ? hl : fl;   h  = use_hs ? hh : fh;
    ss = use_hs ? hss : fss; sh = use_hs ? hsh : fsh;
    ps = use_hs ? hps : fps; su = use_hs ? hsu : fsu;
    rr = use_hs ? hrr : frr;
    a  = cyc + 1;
    ov = 4 + filt_n;
    rel_at = -1;
    case (op)
      0: begin
        s1 = a + (ss + 1) * k;  push(s1, 1, 0, tag);
        s2 = s1 + (sh + 1) * k; push(s2, 0, 0, tag);
        done_at = s2 + ov;      push(done_at, 3, 1, tag);
        bus_sda = 0;
      end
      1: begin
        if (b != bus_sda) push(a + hold_n * k, 1, b, tag);
        t = (hold_n + su + 1 > l + 1) ? hold_n + su + 1 : l + 1;
        r = a + t * k;          push(r, 0, 1, tag);
        if (st_extra >= 0) begin
          rel_at = r + ov - 1 + st_extra;
          hs0 = rel_at + 1;
        end else hs0 = r + ov;
        push(hs0 + ((h + 1) / 2) * k, 2, 1, tag);
        f = hs0 + (h + 1) * k;  push(f, 0, 0, tag);
        done_at = f + ov;       push(done_at, 3, 1, tag);
        bus_sda = b;
      end
      2: begin
        if (!bus_sda) push(a, 1, 1, tag);
        r = a + (rr + 1) * k;   push(r, 0, 1, tag);
        s1 = r + ov + (ss + 1) * k; push(s1, 1, 0, tag);
        s2 = s1 + (sh + 1) * k; push(s2, 0, 0, tag);
        done_at = s2 + ov;      push(done_at, 3, 1, tag);
        bus_sda = 0;
      end
      default: begin
        if (bus_sda) push(a, 1, 0, tag);
        r = a + (l + 1) * k;    push(r, 0, 1, tag);
        e = r + ov + (ps + 1) * k;
        push(e, 1, 1, tag);
        push(e, 3, 1, tag);
        done_at = e;
        bus_sda = 1;
      end
    endcase
    if (rel_at >= 0) stretch = 1'b1;
    req_valid = 1'b1; req_op = 2'(op); req_bit = b; req_hs = hs;
    @(negedge clk);
    req_valid = 1'b0;
    if (rel_at >= 0) begin
      while (cyc < rel_at) @(negedge clk);
      stretch = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_bit = 1'b0; req_hs = 1'b0; stretch = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_o === 1'b1, "R1", "scl after reset", int'(scl_o), 1);
    chk(sda_o === 1'b1, "R1", "sda after reset", int'(sda_o), 1);
    chk(busy_o === 1'b0, "R1", "busy after reset", int'(busy_o), 0);
    chk(done_o === 1'b0 && sample_o === 1'b0, "R1", "pulses after reset", int'(done_o) + int'(sample_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    p_scl = scl_o; p_sda = sda_o; mon_on = 1; done_at = cyc;

    phase(0, 1'b0, 1'b0, "R4", -1);
    phase(1, 1'b1, 1'b0, "R2", -1);
    phase(1, 1'b0, 1'b0, "R3", -1);
    phase(1, 1'b1, 1'b1, "R9", -1);
    phase(1, 1'b1, 1'b0, "R7", 5);
    phase(2, 1'b0, 1'b1, "R6", -1);
    phase(1, 1'b0, 1'b0, "R8", -1);
    phase(3, 1'b0, 1'b0, "R5", -1);
    phase(0, 1'b0, 1'b1, "R9", -1);     // START under high-speed select still uses fast counts
    wait_idle(); hold_n = 4;            // hold + setup beyond low count
    phase(1, 1'b1, 1'b1, "R3", -1);
    wait_idle(); hold_n = 1;
    phase(1, 1'b0, 1'b0, "R10", -1);
    @(negedge clk);
    chk(busy_o === 1'b1, "R10", "busy during phase", int'(busy_o), 1);
    req_valid = 1'b1; req_op = 2'd3;    // ignored while busy
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle(); filt_n = 0;
    phase(1, 1'b1, 1'b0, "R2", -1);
    phase(3, 1'b0, 1'b1, "R5", -1);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R10", "events left unseen", q.size(), 0);
    chk(busy_o === 1'b0, "R10", "idle at end", int'(busy_o), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule